// File: doc/BRIEF.md
# Three-Link Doorbell Mailbox

This block lets two processors, called side A and side B, ring doorbells at each other over three independent links. Each side has its own 32-bit register port in the APB style and three interrupt outputs, one per link. A link carries two 32-bit doorbell words, one for each direction. The word that side A sends on is the same storage that side B receives on, and the reverse direction works the same way. Each side therefore sees every word through two windows: as its transmit status, or as the other side's receive status.

A sender ORs bits into its transmit word through a set port. The receiving side sees a nonzero receive status and raises that link's interrupt. The receiver reads the status, handles the message and writes the same value to a clear port to acknowledge it. The sender writes a new value only when its transmit status reads back zero, and it learns that a send has completed by polling that status. There is no completion interrupt.

The register ports carry single control accesses rather than a data stream, so they are not valid/ready channels. Every access completes in its access phase with `pready` held high. No back-pressure exists, and a port never stalls.

Top module: `mbox_doorbell`

## Requirements
- R1: While reset is asserted, and after it is released, every status word reads zero from both sides and all six interrupt outputs are low.
- R2: A write to a set port ORs the written bits into the addressed status word, and the new value is visible from both sides from the next cycle on.
- R3: A write to a clear port clears exactly the written one-bits of the addressed status word and leaves the other bits unchanged.
- R4: For each link n, `a_irq[n]` is high exactly while the B-to-A word of link n is nonzero, and `b_irq[n]` is high exactly while the A-to-B word of link n is nonzero. The interrupt follows the status word in the cycle after the write that changes the word, and it changes on no other cycle.
- R5: The address map is the same on both ports. The receive window of link 0 starts at 0x000, link 1 at 0x020 and link 2 at 0x200. The transmit window of each link starts 0x100 above its receive window. Within a window, status is at +0x0, set at +0x8 and clear at +0x10. A side's transmit window addresses the word it sends on.
- R6: A read of any other offset returns zero. Writes to such offsets, and writes to status offsets, leave every status word unchanged.
- R7: When both sides write the same status word in one cycle, the clear is applied first and the set second, so the set bits survive.
- R8: `pready` is high in every access phase, so each access takes exactly one setup cycle and one access cycle. Writing zero to a set or clear port leaves the word unchanged.
- R9: The links are independent, and the two directions of a link are independent: a write to one word does not change any other word or its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_psel | input | 1 | Side A select |
| a_penable | input | 1 | Side A access phase |
| a_pwrite | input | 1 | Side A write (1) or read (0) |
| a_paddr | input | 12 | Side A byte address |
| a_pwdata | input | 32 | Side A write data |
| a_prdata | output | 32 | Side A read data |
| a_pready | output | 1 | Side A ready, always high |
| b_psel | input | 1 | Side B select |
| b_penable | input | 1 | Side B access phase |
| b_pwrite | input | 1 | Side B write (1) or read (0) |
| b_paddr | input | 12 | Side B byte address |
| b_pwdata | input | 32 | Side B write data |
| b_prdata | output | 32 | Side B read data |
| b_pready | output | 1 | Side B ready, always high |
| a_irq | output | 3 | Per-link doorbell interrupt to side A |
| b_irq | output | 3 | Per-link doorbell interrupt to side B |

## Verification
The bench sends the same word through both of its windows. A design that kept separate copies per side would show the sender's bits to the sender and never to the receiver. It also fires a clear from one side and a set from the other at one word in the same cycle. A design with the wrong merge order would lose the new doorbell and leave the interrupt low. It probes the irregular link offsets, offsets inside and between windows, and writes aimed at status words. A decoder with an off-by-one window or a writable status word would return stray data or change a word. Partial clears and zero-valued writes catch a design that clears or sets the whole word instead of only the written bits.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W    = 12;
  localparam int WIN_LSB   = 5;
  localparam logic [ADDR_W-1:0] TX_STRIDE = 12'h100;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_STAT = 2'd1,
    REG_SET  = 2'd2,
    REG_CLR  = 2'd3
  } reg_kind_e;

  function automatic logic [ADDR_W-1:0] link_rx_base(input int l);
    case (l)
      0:       return 12'h000;
      1:       return 12'h020;
      2:       return 12'h200;
      default: return 12'h400;
    endcase
  endfunction
endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
  import mbox_pkg::*;
#(
  parameter int NLINK = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NLINK-1:0]  rx_hit,
  output logic [NLINK-1:0]  tx_hit,
  output reg_kind_e         kind
);
  always_comb begin
    case (addr[WIN_LSB-1:0])
      5'h00:   kind = REG_STAT;
      5'h08:   kind = REG_SET;
      5'h10:   kind = REG_CLR;
      default: kind = REG_NONE;
    endcase
  end

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    localparam logic [ADDR_W-1:0] RXB = link_rx_base(l);
    localparam logic [ADDR_W-1:0] TXB = RXB + TX_STRIDE;
    assign rx_hit[l] = (kind != REG_NONE) &&
                       (addr[ADDR_W-1:WIN_LSB] == RXB[ADDR_W-1:WIN_LSB]);
    assign tx_hit[l] = (kind != REG_NONE) &&
                       (addr[ADDR_W-1:WIN_LSB] == TXB[ADDR_W-1:WIN_LSB]);
  end
endmodule

// File: rtl/mbox_apb_side.sv
module mbox_apb_side
  import mbox_pkg::*;
#(
  parameter int NLINK = 3,
  parameter int DW    = 32
) (
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [ADDR_W-1:0]         paddr,
  input  logic [DW-1:0]             pwdata,
  input  logic [NLINK-1:0][DW-1:0]  tx_stat,
  input  logic [NLINK-1:0][DW-1:0]  rx_stat,
  output logic [NLINK-1:0][DW-1:0]  tx_set,
  output logic [NLINK-1:0][DW-1:0]  tx_clr,
  output logic [NLINK-1:0][DW-1:0]  rx_set,
  output logic [NLINK-1:0][DW-1:0]  rx_clr,
  output logic [DW-1:0]             prdata,
  output logic                      pready
);
  logic [NLINK-1:0] rx_hit, tx_hit;
  reg_kind_e        kind;
  logic             wr, rd;

  mbox_addr_dec #(.NLINK(NLINK)) u_dec (
    .addr  (paddr),
    .rx_hit(rx_hit),
    .tx_hit(tx_hit),
    .kind  (kind)
  );

  assign wr     = psel & penable & pwrite;
  assign rd     = psel & penable & ~pwrite;
  assign pready = 1'b1;

  for (genvar l = 0; l < NLINK; l++) begin : g_strb
    assign tx_set[l] = (wr && tx_hit[l] && kind == REG_SET) ? pwdata : '0;
    assign tx_clr[l] = (wr && tx_hit[l] && kind == REG_CLR) ? pwdata : '0;
    assign rx_set[l] = (wr && rx_hit[l] && kind == REG_SET) ? pwdata : '0;
    assign rx_clr[l] = (wr && rx_hit[l] && kind == REG_CLR) ? pwdata : '0;
  end

  always_comb begin
    prdata = '0;
    if (rd && kind == REG_STAT) begin
      for (int l = 0; l < NLINK; l++) begin
        if (rx_hit[l]) prdata = prdata | rx_stat[l];
        if (tx_hit[l]) prdata = prdata | tx_stat[l];
      end
    end
  end
endmodule

// File: rtl/mbox_status_word.sv
module mbox_status_word #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_a,
  input  logic [DW-1:0] clr_a,
  input  logic [DW-1:0] set_b,
  input  logic [DW-1:0] clr_b,
  output logic [DW-1:0] q
);
  logic [DW-1:0] cleared;
  assign cleared = q & ~(clr_a | clr_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= cleared | set_a | set_b;
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int NLINK = 3,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_psel,
  input  logic              a_penable,
  input  logic              a_pwrite,
  input  logic [ADDR_W-1:0] a_paddr,
  input  logic [DW-1:0]     a_pwdata,
  output logic [DW-1:0]     a_prdata,
  output logic              a_pready,
  input  logic              b_psel,
  input  logic              b_penable,
  input  logic              b_pwrite,
  input  logic [ADDR_W-1:0] b_paddr,
  input  logic [DW-1:0]     b_pwdata,
  output logic [DW-1:0]     b_prdata,
  output logic              b_pready,
  output logic [NLINK-1:0]  a_irq,
  output logic [NLINK-1:0]  b_irq
);
  // one word per direction per link, shared by both sides
  logic [NLINK-1:0][DW-1:0] a2b, b2a;
  logic [NLINK-1:0][DW-1:0] a_tx_set, a_tx_clr, a_rx_set, a_rx_clr;
  logic [NLINK-1:0][DW-1:0] b_tx_set, b_tx_clr, b_rx_set, b_rx_clr;

  mbox_apb_side #(.NLINK(NLINK), .DW(DW)) u_side_a (
    .psel(a_psel), .penable(a_penable), .pwrite(a_pwrite),
    .paddr(a_paddr), .pwdata(a_pwdata),
    .tx_stat(a2b), .rx_stat(b2a),
    .tx_set(a_tx_set), .tx_clr(a_tx_clr),
    .rx_set(a_rx_set), .rx_clr(a_rx_clr),
    .prdata(a_prdata), .pready(a_pready)
  );

  mbox_apb_side #(.NLINK(NLINK), .DW(DW)) u_side_b (
    .psel(b_psel), .penable(b_penable), .pwrite(b_pwrite),
    .paddr(b_paddr), .pwdata(b_pwdata),
    .tx_stat(b2a), .rx_stat(a2b),
    .tx_set(b_tx_set), .tx_clr(b_tx_clr),
    .rx_set(b_rx_set), .rx_clr(b_rx_clr),
    .prdata(b_prdata), .pready(b_pready)
  );

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    mbox_status_word #(.DW(DW)) u_a2b (
      .clk(clk), .rst_n(rst_n),
      .set_a(a_tx_set[l]), .clr_a(a_tx_clr[l]),
      .set_b(b_rx_set[l]), .clr_b(b_rx_clr[l]),
      .q(a2b[l])
    );
    mbox_status_word #(.DW(DW)) u_b2a (
      .clk(clk), .rst_n(rst_n),
      .set_a(a_rx_set[l]), .clr_a(a_rx_clr[l]),
      .set_b(b_tx_set[l]), .clr_b(b_tx_clr[l]),
      .q(b2a[l])
    );
    assign a_irq[l] = |b2a[l];
    assign b_irq[l] = |a2b[l];
  end
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        a_psel,
  input logic        a_penable,
  input logic        a_pwrite,
  input logic [11:0] a_paddr,
  input logic [31:0] a_pwdata,
  input logic [31:0] a_prdata,
  input logic        b_psel,
  input logic        b_penable,
  input logic        b_pwrite,
  input logic [11:0] b_paddr,
  input logic [2:0]  a_irq,
  input logic [2:0]  b_irq
);
  logic wr_a, wr_b;
  assign wr_a = a_psel && a_penable && a_pwrite;
  assign wr_b = b_psel && b_penable && b_pwrite;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (a_irq == 3'b000 && b_irq == 3'b000));

  // R2
  set_rings_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && a_paddr == 12'h108 && a_pwdata != 32'h0) |=> b_irq[0]);

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && a_paddr == 12'h110 && a_pwdata == 32'hFFFF_FFFF &&
     !(wr_b && b_paddr == 12'h008)) |=> !b_irq[0]);

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_a || wr_b) |=> ($stable(a_irq) && $stable(b_irq)));

  // R6
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_psel && a_penable && !a_pwrite && a_paddr == 12'h004) |-> a_prdata == 32'h0);
endmodule

bind mbox_doorbell mbox_doorbell_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_psel(a_psel), .a_penable(a_penable), .a_pwrite(a_pwrite),
  .a_paddr(a_paddr), .a_pwdata(a_pwdata), .a_prdata(a_prdata),
  .b_psel(b_psel), .b_penable(b_penable), .b_pwrite(b_pwrite),
  .b_paddr(b_paddr),
  .a_irq(a_irq), .b_irq(b_irq)
);

// File: tb/mbox_doorbell_bench.sv
`timescale 1ns/1ps
module mbox_doorbell_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_psel = 0, a_penable = 0, a_pwrite = 0;
  logic [11:0] a_paddr = '0;
  logic [31:0] a_pwdata = '0;
  logic        b_psel = 0, b_penable = 0, b_pwrite = 0;
  logic [11:0] b_paddr = '0;
  logic [31:0] b_pwdata = '0;
  logic [31:0] a_prdata, b_prdata;
  logic        a_pready, b_pready;
  logic [2:0]  a_irq, b_irq;

  int vectors = 0;
  int errors  = 0;

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t qa[$];
  item_t qb[$];

  // model words: index dir*3+link, dir 0 = A to B, dir 1 = B to A
  logic [31:0] w [6];

  always #2 clk = ~clk;

  mbox_doorbell u_mbox_doorbell (
    .clk(clk), .rst_n(rst_n),
    .a_psel(a_psel), .a_penable(a_penable), .a_pwrite(a_pwrite),
    .a_paddr(a_paddr), .a_pwdata(a_pwdata), .a_prdata(a_prdata), .a_pready(a_pready),
    .b_psel(b_psel), .b_penable(b_penable), .b_pwrite(b_pwrite),
    .b_paddr(b_paddr), .b_pwdata(b_pwdata), .b_prdata(b_prdata), .b_pready(b_pready),
    .a_irq(a_irq), .b_irq(b_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 status, 2 set, 3 clear
  function automatic void bdec(input int side, input logic [11:0] addr,
                               output int idx, output int kind);
    idx = 0; kind = 0;
    for (int l = 0; l < 3; l++) begin
      logic [11:0] base;
      base = (l == 0) ? 12'h000 : ((l == 1) ? 12'h020 : 12'h200);
      for (int t = 0; t < 2; t++) begin
        logic [11:0] wb;
        int dir;
        wb  = base + ((t == 1) ? 12'h100 : 12'h000);
        dir = (side == 0) ? ((t == 1) ? 0 : 1) : ((t == 1) ? 1 : 0);
        if (addr == wb)         begin kind = 1; idx = dir*3 + l; end
        if (addr == wb + 12'h8) begin kind = 2; idx = dir*3 + l; end
        if (addr == wb + 12'h10) begin kind = 3; idx = dir*3 + l; end
      end
    end
  endfunction

  function automatic logic [31:0] mread(input int side, input logic [11:0] addr);
    int idx, kind;
    bdec(side, addr, idx, kind);
    return (kind == 1) ? w[idx] : 32'h0;
  endfunction

  // driver: one transfer per side in the same two cycles, reads queued for the monitor
  task automatic xfer(input bit da, input bit wa, input logic [11:0] aa, input logic [31:0] ma,
                      input bit db, input bit wbk, input logic [11:0] ab, input logic [31:0] mb,
                      input string req);
    logic [31:0] setm [6];
    logic [31:0] clrm [6];
    int idx, kind;
    if (da && !wa) qa.push_back('{mread(0, aa), req});
    if (db && !wbk) qb.push_back('{mread(1, ab), req});
    @(posedge clk); #1;
    a_psel = da; a_pwrite = wa; a_paddr = aa; a_pwdata = ma; a_penable = 0;
    b_psel = db; b_pwrite = wbk; b_paddr = ab; b_pwdata = mb; b_penable = 0;
    @(posedge clk); #1;
    a_penable = da; b_penable = db;
    @(posedge clk); #1;
    a_psel = 0; a_penable = 0; b_psel = 0; b_penable = 0;
    for (int i = 0; i < 6; i++) begin setm[i] = '0; clrm[i] = '0; end
    if (da && wa) begin
      bdec(0, aa, idx, kind);
      if (kind == 2) setm[idx] |= ma;
      if (kind == 3) clrm[idx] |= ma;
    end
    if (db && wbk) begin
      bdec(1, ab, idx, kind);
      if (kind == 2) setm[idx] |= mb;
      if (kind == 3) clrm[idx] |= mb;
    end
    for (int i = 0; i < 6; i++) w[i] = (w[i] & ~clrm[i]) | setm[i];
  endtask

  task automatic wr_a(input logic [11:0] a, input logic [31:0] d, input string r);
    xfer(1, 1, a, d, 0, 0, 12'h0, 32'h0, r);
  endtask
  task automatic wr_b(input logic [11:0] a, input logic [31:0] d, input string r);
    xfer(0, 0, 12'h0, 32'h0, 1, 1, a, d, r);
  endtask
  task automatic rd_both(input logic [11:0] aa, input logic [11:0] ab, input string r);
    xfer(1, 0, aa, 32'h0, 1, 0, ab, 32'h0, r);
  endtask

  task automatic chk_irq(input string r);
    logic [2:0] ea, eb;
    for (int l = 0; l < 3; l++) begin
      ea[l] = (w[3 + l] != 0);
      eb[l] = (w[l] != 0);
    end
    check({r, " a_irq"}, {29'h0, a_irq}, {29'h0, ea});
    check({r, " b_irq"}, {29'h0, b_irq}, {29'h0, eb});
  endtask

  // monitor: pops expected read data at the access phase
  always @(negedge clk) begin
    if (a_psel && a_penable) begin
      check("R8 a_pready", {31'h0, a_pready}, 32'h1);
      if (!a_pwrite) begin
        item_t it;
        it = qa.pop_front();
        check({it.req, " side A read"}, a_prdata, it.exp);
      end
    end
    if (b_psel && b_penable) begin
      check("R8 b_pready", {31'h0, b_pready}, 32'h1);
      if (!b_pwrite) begin
        item_t it;
        it = qb.pop_front();
        check({it.req, " side B read"}, b_prdata, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) w[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk_irq("R1 in reset");
    rst_n = 1'b1;
    // R1 all status words read zero
    rd_both(12'h000, 12'h100, "R1");
    rd_both(12'h120, 12'h020, "R1");
    rd_both(12'h300, 12'h200, "R1");
    chk_irq("R1 after reset");

    // R2 / R4 / R5: A rings link 0, seen on B receive and A transmit
    wr_a(12'h108, 32'h0000_0005, "R2");
    chk_irq("R4 link0 ring");
    rd_both(12'h100, 12'h000, "R2 R5");
    wr_a(12'h108, 32'h0000_0030, "R2 or");
    rd_both(12'h100, 12'h000, "R2 or");

    // R3 partial clear from receiver, R8 zero writes
    wr_b(12'h010, 32'h0000_0005, "R3");
    rd_both(12'h100, 12'h000, "R3 partial");
    wr_b(12'h010, 32'h0, "R8 zero clr");
    wr_a(12'h108, 32'h0, "R8 zero set");
    rd_both(12'h100, 12'h000, "R8");
    chk_irq("R4 still set");
    wr_b(12'h010, 32'h0000_0030, "R3");
    chk_irq("R4 drop");
    rd_both(12'h100, 12'h000, "R3 empty");

    // R5 / R9 other links and the reverse direction
    wr_b(12'h128, 32'hDEAD_0001, "R5 link1");
    chk_irq("R9 link1 only");
    rd_both(12'h020, 12'h120, "R5 link1");
    wr_a(12'h308, 32'h8000_0000, "R5 link2");
    chk_irq("R9 link2");
    rd_both(12'h300, 12'h200, "R5 link2");
    rd_both(12'h000, 12'h100, "R9 link0 untouched");

    // R6 holes and status writes
    rd_both(12'h004, 12'h040, "R6 hole");
    rd_both(12'h0FC, 12'h118, "R6 hole");
    wr_a(12'h040, 32'hFFFF_FFFF, "R6 hole write");
    wr_b(12'h200, 32'hFFFF_FFFF, "R6 status write");
    wr_a(12'h320, 32'h0000_00FF, "R6 hole write");
    rd_both(12'h300, 12'h200, "R6");
    rd_both(12'h020, 12'h000, "R6");
    chk_irq("R6");

    // R7 clear from A and set from B on the same word in one cycle
    wr_a(12'h108, 32'h0000_000F, "R7 prep");
    xfer(1, 1, 12'h110, 32'hFFFF_FFFF, 1, 1, 12'h008, 32'h0000_00A0, "R7");
    rd_both(12'h100, 12'h000, "R7 set survives");
    chk_irq("R7");

    // drain the remaining words
    wr_a(12'h030, 32'hFFFF_FFFF, "R3 link1");
    wr_b(12'h210, 32'hFFFF_FFFF, "R3 link2");
    wr_b(12'h010, 32'hFFFF_FFFF, "R3 link0");
    chk_irq("R4 all idle");
    rd_both(12'h120, 12'h300, "R3 idle");

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule